// File: doc/BRIEF.md
# Hot-Plug Slot Control and Status Registers

This block holds the slot control and slot status registers of a hot-plug capable downstream port. Software reaches them through a 32-bit configuration-style port with byte enables. Both registers share one aligned dword at byte offset 0x18 of the capability: control is in the low half and status is in the high half, which starts at offset 0x1A. The port side of the block feeds in attention button presses and presence change requests. The block drives the power and attention indicator codes, and it raises a hot-plug interrupt.

The interrupt condition is true only when two things hold. The hot-plug interrupt enable must be set, and at least one event status bit must be set together with its matching enable. A mode input selects how the condition is signalled. In level mode a level output follows the condition. In message mode a one-cycle pulse marks each rise of the condition.

Every write that reaches the control half of the dword counts as one command. The electromechanical interlock control bit does not store anything: writing it with 1 flips the interlock status. A presence change request is refused while the interlock is engaged.

Top module: `hp_slot_regs`

## Requirements
- R1: After a synchronous reset, all event enables, the interrupt enable, the interlock status and the three event bits read 0. Both indicator fields read 11 (off), and reading dword 0x18 returns 0x0000_03C0.
- R2: The attention indicator field is at control bits 7:6 and the power indicator field is at bits 9:8. The codes are 01 on, 10 blink and 11 off. A write of code 00 leaves the field unchanged. The indicator outputs show the stored fields.
- R3: Writing 1 to control bit 11 flips interlock status (status bit 7, dword bit 23) once per write. Control bit 11 always reads 0.
- R4: Any write with byte enable 0 or 1 set at the slot dword sets command completed (status bit 4) on the same clock edge that applies the write.
- R5: Status bits 0 (button pressed), 3 (presence changed) and 4 (command completed) are cleared by writing 1 through byte enable 2. Writing 0 to these bits has no effect. Presence state (bit 6) and interlock status (bit 7) ignore status writes.
- R6: A one-cycle button event sets status bit 0.
- R7: A presence request with interlock released loads presence state and sets presence changed. A presence request with interlock engaged changes neither bit and pulses the error output for one cycle.
- R8: In level mode, the level output shows one cycle later the condition (interrupt enable, bit 5) AND (any event bit AND its enable at control bits 0, 3 and 4). The message output stays low in this mode.
- R9: In message mode, a one-cycle pulse follows each 0-to-1 change of the condition. A repeated event whose bit is already set produces no pulse, and the level output stays low.
- R10: A read returns the dword on the next cycle with control in bits 15:0 and status in bits 31:16. An address outside the slot dword reads 0.
- R11: When an event sets a status bit in the same cycle as a write-1-to-clear of that bit, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe |
| cfg_rd | input | 1 | Read strobe |
| cfg_addr | input | ADDR_W | Byte address inside the capability |
| cfg_wdata | input | 32 | Write data |
| cfg_be | input | 4 | Byte enables |
| cfg_rdata | output | 32 | Registered read data |
| btn_evt | input | 1 | Attention button press, one cycle |
| pres_req | input | 1 | Presence change request, one cycle |
| pres_val | input | 1 | New presence state for pres_req |
| msg_mode | input | 1 | 1 selects pulse signalling, 0 selects level |
| irq_level | output | 1 | Level interrupt |
| irq_msg | output | 1 | One-cycle notification pulse |
| hp_err | output | 1 | Presence request refused because the interlock is engaged |
| pwr_ind | output | 2 | Power indicator code |
| attn_ind | output | 2 | Attention indicator code |

## Verification
The assertions assume that btn_evt and pres_req are synchronous strobes, that pres_val is valid whenever pres_req is high, and that no input is unknown outside reset. They also assume that msg_mode changes only between clock edges. The bench drives every input on the falling edge and holds each event strobe for exactly one cycle. It changes msg_mode only while the interrupt condition is false, so no notification is lost or doubled when the mode changes. Reads and writes are single-cycle strobes that never overlap with reset.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
  localparam int CFG_DW  = 32;
  localparam int CFG_BW  = CFG_DW / 8;
  localparam int HALF_W  = CFG_DW / 2;
  localparam int STS_BYTE = 2;

  localparam int NUM_EV = 3;
  localparam int EV_ABP = 0;
  localparam int EV_PDC = 1;
  localparam int EV_CC  = 2;
  // bit position of each event in status and of its enable in control
  localparam int EV_BIT [NUM_EV] = '{0, 3, 4};

  localparam int B_HPIE = 5;
  localparam int B_PDS  = 6;
  localparam int B_EIS  = 7;
  localparam int B_EIC  = 11;

  localparam int NUM_IND = 2;
  localparam int IND_ATTN = 0;
  localparam int IND_PWR  = 1;
  localparam int IND_LO [NUM_IND] = '{6, 8};

  typedef enum logic [1:0] {
    IND_RSVD  = 2'b00,
    IND_ON    = 2'b01,
    IND_BLINK = 2'b10,
    IND_OFF   = 2'b11
  } ind_e;
endpackage

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
  import hp_slot_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           wr_b,
  input  logic [HALF_W-1:0]    wdata,
  output logic [NUM_EV-1:0]    en_q,
  output logic                 hpie_q,
  output logic [1:0]           ind_o [NUM_IND],
  output logic                 cmd_done,
  output logic                 eis_flip
);
  logic unused_ctrl_bits;
  assign unused_ctrl_bits = ^{wdata[15:12], wdata[10], wdata[2:1]};

  assign cmd_done = |wr_b;
  assign eis_flip = wr_b[B_EIC / 8] & wdata[B_EIC];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      hpie_q <= 1'b0;
    end else if (wr_b[0]) begin
      for (int i = 0; i < NUM_EV; i++) en_q[i] <= wdata[EV_BIT[i]];
      hpie_q <= wdata[B_HPIE];
    end
  end

  for (genvar k = 0; k < NUM_IND; k++) begin : g_ind
    localparam int LO = IND_LO[k];
    logic [1:0] field_q;
    always_ff @(posedge clk) begin
      if (rst)
        field_q <= IND_OFF;
      else if (wr_b[LO / 8] && (wdata[LO +: 2] != IND_RSVD))
        field_q <= wdata[LO +: 2];
    end
    assign ind_o[k] = field_q;
  end
endmodule

// File: rtl/hp_slot_status.sv
module hp_slot_status
  import hp_slot_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_en,
  input  logic [7:0]        clr_byte,
  input  logic              cmd_done,
  input  logic              eis_flip,
  input  logic              btn_evt,
  input  logic              pres_req,
  input  logic              pres_val,
  output logic [NUM_EV-1:0] ev_q,
  output logic              pds_q,
  output logic              eis_q,
  output logic              err_q
);
  logic [NUM_EV-1:0] ev_set;
  logic [NUM_EV-1:0] ev_clr;
  logic              pres_ok;
  logic              unused_sts_bits;

  assign unused_sts_bits = ^{clr_byte[7:5], clr_byte[2:1]};
  assign pres_ok = pres_req & ~eis_q;

  always_comb begin
    ev_set         = '0;
    ev_set[EV_ABP] = btn_evt;
    ev_set[EV_PDC] = pres_ok;
    ev_set[EV_CC]  = cmd_done;
    for (int i = 0; i < NUM_EV; i++) ev_clr[i] = clr_en & clr_byte[EV_BIT[i]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_q  <= '0;
      pds_q <= 1'b0;
      eis_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      ev_q  <= ev_set | (ev_q & ~ev_clr);
      eis_q <= eis_q ^ eis_flip;
      err_q <= pres_req & eis_q;
      if (pres_ok) pds_q <= pres_val;
    end
  end
endmodule

// File: rtl/hp_slot_notify.sv
module hp_slot_notify
  import hp_slot_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              msg_mode,
  input  logic [NUM_EV-1:0] ev,
  input  logic [NUM_EV-1:0] en,
  input  logic              hpie,
  output logic              irq_level,
  output logic              irq_msg
);
  logic cond;
  logic cond_q;

  assign cond = hpie & (|(ev & en));

  always_ff @(posedge clk) begin
    if (rst) begin
      cond_q    <= 1'b0;
      irq_level <= 1'b0;
      irq_msg   <= 1'b0;
    end else begin
      cond_q    <= cond;
      irq_level <= ~msg_mode & cond;
      irq_msg   <= msg_mode & cond & ~cond_q;
    end
  end
endmodule

// File: rtl/hp_slot_regs.sv
module hp_slot_regs
  import hp_slot_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] SLOT_OFFS = 12'h018
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  input  logic [CFG_BW-1:0] cfg_be,
  output logic [CFG_DW-1:0] cfg_rdata,
  input  logic              btn_evt,
  input  logic              pres_req,
  input  logic              pres_val,
  input  logic              msg_mode,
  output logic              irq_level,
  output logic              irq_msg,
  output logic              hp_err,
  output logic [1:0]        pwr_ind,
  output logic [1:0]        attn_ind
);
  localparam int DW_LSB = $clog2(CFG_BW);

  logic              slot_hit;
  logic [1:0]        ctrl_wr_b;
  logic              sts_clr_en;
  logic [NUM_EV-1:0] en_q;
  logic              hpie_q;
  logic [1:0]        ind_v [NUM_IND];
  logic              cmd_done;
  logic              eis_flip;
  logic [NUM_EV-1:0] ev_q;
  logic              pds_q;
  logic              eis_q;
  logic [HALF_W-1:0] ctrl_word;
  logic [HALF_W-1:0] sts_word;
  logic              unused_top_bits;

  assign unused_top_bits = ^{cfg_wdata[CFG_DW-1:24], cfg_be[CFG_BW-1], cfg_addr[DW_LSB-1:0],
                             SLOT_OFFS[DW_LSB-1:0]};

  assign slot_hit   = (cfg_addr[ADDR_W-1:DW_LSB] == SLOT_OFFS[ADDR_W-1:DW_LSB]);
  assign ctrl_wr_b  = {2{cfg_wr & slot_hit}} & cfg_be[1:0];
  assign sts_clr_en = cfg_wr & slot_hit & cfg_be[STS_BYTE];

  hp_slot_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wr_b     (ctrl_wr_b),
    .wdata    (cfg_wdata[HALF_W-1:0]),
    .en_q     (en_q),
    .hpie_q   (hpie_q),
    .ind_o    (ind_v),
    .cmd_done (cmd_done),
    .eis_flip (eis_flip)
  );

  hp_slot_status u_sts (
    .clk      (clk),
    .rst      (rst),
    .clr_en   (sts_clr_en),
    .clr_byte (cfg_wdata[STS_BYTE*8 +: 8]),
    .cmd_done (cmd_done),
    .eis_flip (eis_flip),
    .btn_evt  (btn_evt),
    .pres_req (pres_req),
    .pres_val (pres_val),
    .ev_q     (ev_q),
    .pds_q    (pds_q),
    .eis_q    (eis_q),
    .err_q    (hp_err)
  );

  hp_slot_notify u_ntf (
    .clk       (clk),
    .rst       (rst),
    .msg_mode  (msg_mode),
    .ev        (ev_q),
    .en        (en_q),
    .hpie      (hpie_q),
    .irq_level (irq_level),
    .irq_msg   (irq_msg)
  );

  assign attn_ind = ind_v[IND_ATTN];
  assign pwr_ind  = ind_v[IND_PWR];

  always_comb begin
    ctrl_word = '0;
    sts_word  = '0;
    for (int i = 0; i < NUM_EV; i++) begin
      ctrl_word[EV_BIT[i]] = en_q[i];
      sts_word[EV_BIT[i]]  = ev_q[i];
    end
    ctrl_word[B_HPIE] = hpie_q;
    for (int k = 0; k < NUM_IND; k++) ctrl_word[IND_LO[k] +: 2] = ind_v[k];
    sts_word[B_PDS] = pds_q;
    sts_word[B_EIS] = eis_q;
  end

  always_ff @(posedge clk) begin
    if (rst)
      cfg_rdata <= '0;
    else if (cfg_rd)
      cfg_rdata <= slot_hit ? {sts_word, ctrl_word} : '0;
  end
endmodule

// File: rtl/hp_slot_regs_chk.sv
module hp_slot_regs_chk (
  input logic        clk,
  input logic        rst,
  input logic        cfg_wr,
  input logic        slot_hit,
  input logic [3:0]  cfg_be,
  input logic [31:0] cfg_wdata,
  input logic [31:0] cfg_rdata,
  input logic        pres_req,
  input logic        msg_mode,
  input logic        hpie,
  input logic        cc,
  input logic        eis,
  input logic        pds,
  input logic        irq_level,
  input logic        irq_msg,
  input logic        hp_err,
  input logic [1:0]  pwr_ind,
  input logic [1:0]  attn_ind
);
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (pwr_ind == 2'b11 && attn_ind == 2'b11 && !eis && !cc)); // R1

  AST_IND_CODE_VALID: assert property (@(posedge clk) disable iff (rst)
    (pwr_ind != 2'b00 && attn_ind != 2'b00)); // R2

  AST_INTERLOCK_FLIP: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && slot_hit && cfg_be[1] && cfg_wdata[11]) |=> (eis != $past(eis))); // R3

  AST_EIC_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !cfg_rdata[11]); // R3

  AST_CMD_COMPLETES: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && slot_hit && (cfg_be[1:0] != 2'b00)) |=> cc); // R4

  AST_LOCKED_REJECT: assert property (@(posedge clk) disable iff (rst)
    (pres_req && eis) |=> (hp_err && $stable(pds))); // R7

  AST_LEVEL_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    irq_level |-> $past(hpie && !msg_mode)); // R8

  AST_MSG_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    irq_msg |=> !irq_msg); // R9

  AST_MODE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(irq_msg && irq_level)); // R9
endmodule

bind hp_slot_regs hp_slot_regs_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_wr    (cfg_wr),
  .slot_hit  (slot_hit),
  .cfg_be    (cfg_be),
  .cfg_wdata (cfg_wdata),
  .cfg_rdata (cfg_rdata),
  .pres_req  (pres_req),
  .msg_mode  (msg_mode),
  .hpie      (hpie_q),
  .cc        (ev_q[hp_slot_pkg::EV_CC]),
  .eis       (eis_q),
  .pds       (pds_q),
  .irq_level (irq_level),
  .irq_msg   (irq_msg),
  .hp_err    (hp_err),
  .pwr_ind   (pwr_ind),
  .attn_ind  (attn_ind)
);

// File: tb/hp_slot_regs_bench.sv
`timescale 1ns/1ps
module hp_slot_regs_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_rdata;
  logic        btn_evt = 1'b0, pres_req = 1'b0, pres_val = 1'b0, msg_mode = 1'b0;
  logic        irq_level, irq_msg, hp_err;
  logic [1:0]  pwr_ind, attn_ind;

  int total = 0;
  int bad = 0;
  int pulses = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hp_slot_regs u_hp_slot_regs (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_be(cfg_be), .cfg_rdata(cfg_rdata),
    .btn_evt(btn_evt), .pres_req(pres_req), .pres_val(pres_val), .msg_mode(msg_mode),
    .irq_level(irq_level), .irq_msg(irq_msg), .hp_err(hp_err),
    .pwr_ind(pwr_ind), .attn_ind(attn_ind)
  );

  // behavioural reference of the requirements
  logic m_abpe, m_pdce, m_cce, m_hpie, m_abp, m_pdc, m_cc, m_pds, m_eis, m_cq;
  logic [1:0] m_aic, m_pic;
  logic e_lvl, e_msg, e_err;
  logic [31:0] e_rd;
  logic m_hit, m_cond, m_wr_ctl, m_clr;
  logic [15:0] m_cw, m_sw;

  always @(posedge clk) begin
    if (rst) begin
      {m_abpe, m_pdce, m_cce, m_hpie, m_abp, m_pdc, m_cc, m_pds, m_eis, m_cq} <= '0;
      m_aic <= 2'b11; m_pic <= 2'b11;
      e_lvl <= 1'b0; e_msg <= 1'b0; e_err <= 1'b0; e_rd <= '0;
    end else begin
      m_hit    = (cfg_addr[11:2] == 10'd6);
      m_cond   = m_hpie && ((m_abp && m_abpe) || (m_pdc && m_pdce) || (m_cc && m_cce));
      m_wr_ctl = cfg_wr && m_hit && (cfg_be[1:0] != 2'b00);
      m_clr    = cfg_wr && m_hit && cfg_be[2];
      m_cw = {4'b0, 1'b0, 1'b0, m_pic, m_aic, m_hpie, m_cce, m_pdce, 2'b0, m_abpe};
      m_sw = {8'b0, m_eis, m_pds, 1'b0, m_cc, m_pdc, 2'b0, m_abp};
      e_lvl <= !msg_mode && m_cond;
      e_msg <= msg_mode && m_cond && !m_cq;
      m_cq  <= m_cond;
      e_err <= pres_req && m_eis;
      if (cfg_rd) e_rd <= m_hit ? {m_sw, m_cw} : 32'h0;
      if (cfg_wr && m_hit && cfg_be[0]) begin
        m_abpe <= cfg_wdata[0]; m_pdce <= cfg_wdata[3];
        m_cce  <= cfg_wdata[4]; m_hpie <= cfg_wdata[5];
        if (cfg_wdata[7:6] != 2'b00) m_aic <= cfg_wdata[7:6];
      end
      if (cfg_wr && m_hit && cfg_be[1]) begin
        if (cfg_wdata[9:8] != 2'b00) m_pic <= cfg_wdata[9:8];
        if (cfg_wdata[11]) m_eis <= !m_eis;
      end
      m_abp <= btn_evt || (m_abp && !(m_clr && cfg_wdata[16]));
      m_pdc <= (pres_req && !m_eis) || (m_pdc && !(m_clr && cfg_wdata[19]));
      m_cc  <= m_wr_ctl || (m_cc && !(m_clr && cfg_wdata[20]));
      if (pres_req && !m_eis) m_pds <= pres_val;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R8 irq_level", {31'b0, irq_level}, {31'b0, e_lvl});
      chk("R9 irq_msg", {31'b0, irq_msg}, {31'b0, e_msg});
      chk("R7 hp_err", {31'b0, hp_err}, {31'b0, e_err});
      chk("R2 indicators", {28'b0, pwr_ind, attn_ind}, {28'b0, m_pic, m_aic});
      chk("R10 rdata", cfg_rdata, e_rd);
      if (irq_msg) pulses++;
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d, logic [3:0] be);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_be = be;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = '0;
  endtask

  task automatic rd_chk(logic [11:0] a, logic [31:0] exp, string tag);
    cfg_rd = 1'b1; cfg_addr = a;
    @(negedge clk);
    cfg_rd = 1'b0;
    chk(tag, cfg_rdata, exp);
  endtask

  task automatic press();
    btn_evt = 1'b1;
    @(negedge clk);
    btn_evt = 1'b0;
  endtask

  task automatic presence(logic v);
    pres_req = 1'b1; pres_val = v;
    @(negedge clk);
    pres_req = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    rd_chk(12'h018, 32'h0000_03C0, "R1 reset dword");
    chk("R1 reset irq", {30'b0, irq_level, irq_msg}, 32'h0);

    wr(12'h018, 32'h0000_0240, 4'b0011);
    chk("R2 ind set", {28'b0, pwr_ind, attn_ind}, {28'b0, 2'b10, 2'b01});
    rd_chk(12'h018, 32'h0010_0240, "R4 cc after write");
    wr(12'h018, 32'h0000_0000, 4'b0011);
    chk("R2 code 00 ignored", {28'b0, pwr_ind, attn_ind}, {28'b0, 2'b10, 2'b01});
    wr(12'h018, 32'h0010_0000, 4'b0100);
    rd_chk(12'h018, 32'h0000_0240, "R5 cc cleared");

    wr(12'h018, 32'h0000_0800, 4'b0010);
    rd_chk(12'h018, 32'h0090_0240, "R3 interlock on, eic reads 0");
    presence(1'b1);
    chk("R7 refused", {31'b0, hp_err}, 32'h1);
    rd_chk(12'h018, 32'h0090_0240, "R7 no change when locked");
    wr(12'h018, 32'h0000_0800, 4'b0010);
    rd_chk(12'h018, 32'h0010_0240, "R3 interlock off");
    presence(1'b1);
    rd_chk(12'h018, 32'h0058_0240, "R7 presence accepted");
    wr(12'h018, 32'h00C0_0000, 4'b0100);
    rd_chk(12'h018, 32'h0058_0240, "R5 pds eis not clearable");
    wr(12'h018, 32'h0019_0000, 4'b0100);
    rd_chk(12'h018, 32'h0040_0240, "R5 all events cleared");

    wr(12'h018, 32'h0000_0061, 4'b0011);
    press();
    @(negedge clk);
    chk("R8 level raised", {31'b0, irq_level}, 32'h1);
    rd_chk(12'h018, 32'h0051_0261, "R6 button sets abp");
    wr(12'h018, 32'h0001_0000, 4'b0100);
    @(negedge clk);
    chk("R8 level dropped", {31'b0, irq_level}, 32'h0);

    msg_mode = 1'b1;
    wr(12'h018, 32'h0010_0000, 4'b0100);
    pulses = 0;
    press();
    repeat (3) @(negedge clk);
    chk("R9 one pulse", pulses, 1);
    press();
    repeat (3) @(negedge clk);
    chk("R9 duplicate no pulse", pulses, 1);

    cfg_wr = 1'b1; cfg_addr = 12'h018; cfg_wdata = 32'h0001_0000; cfg_be = 4'b0100;
    btn_evt = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = '0; btn_evt = 1'b0;
    rd_chk(12'h018, 32'h0041_0261, "R11 event beats clear");
    wr(12'h018, 32'h0010_0261, 4'b0101);
    rd_chk(12'h018, 32'h0051_0261, "R11 command beats clear");
    rd_chk(12'h01C, 32'h0000_0000, "R10 miss reads zero");
    chk("R9 no level in msg mode", {31'b0, irq_level}, 32'h0);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule